// File: doc/BRIEF.md
# Function Configuration Register File

This block holds the 256-byte configuration space of a single bus function. A host-side decoder presents one access per cycle: a byte offset, a size code and, for writes, a little-endian data word. Reads return 1, 2 or 4 bytes assembled least significant byte first. Writes normally land byte by byte, and the header-type byte decides which bytes are protected from change.

Full 32-bit writes to one of the six base address registers go through a separate path when that region has a nonzero size. In that path the low address bits the region cannot decode are cleared, and the region's fixed type bits are forced in. The expansion ROM register works the same way, but its bit 0 is kept as the ROM enable. The identity fields, class code, header type, interrupt pin and all region sizes and type bits are parameters. A one-cycle pulse tells the surrounding logic that the decode windows must be recomputed.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset the space holds these values, and every other byte is zero. The vendor ID is at 0x00–0x01, low byte first. The device ID is at 0x02–0x03. The revision is at 0x08. The 24-bit class code is at 0x09–0x0B, low byte first. The header type is at 0x0E and the interrupt pin at 0x3D. Each base address register at 0x10+4·n (n = 0..5) holds its type bits if its size is nonzero.
- R2: An access is issued by acc_valid=1 with acc_write=0. The size code 0 selects one byte, 1 selects two bytes (offset bit 0 ignored) and 2 or 3 selects four bytes (offset bits 1:0 ignored). In the next cycle rd_data holds the addressed bytes with the lowest offset in bits 7:0, and the unused upper bits read as zero.
- R3: A byte-path write stores byte k of wr_data (bits 8k+7:8k) at aligned offset + k for each k below the access length. The new value is visible to a read issued in the next cycle, and bytes outside the access are unchanged.
- R4: When the header-type byte is 0x00 or 0x80, byte-path writes leave these bytes unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x30–0x33 and 0x3D.
- R5: When the header-type byte has any other value, byte-path writes leave 0x00–0x03, 0x08–0x0B, 0x0E, 0x38–0x3B and 0x3D unchanged, and all other bytes are writable.
- R6: A 4-byte write to a base address register of nonzero size S stores (wr_data & ~(S−1)) | type, whatever the header type.
- R7: A 4-byte write to the ROM register at 0x30 with nonzero ROM size S stores wr_data & (~(S−1) | 1).
- R8: A 4-byte write to a region register whose size is zero takes the byte path, with the protection of R4/R5.
- R9: remap_pulse is 1 in the cycle after any write whose bytes overlap offsets 0x04–0x05.
- R10: remap_pulse is also 1 in the cycle after a masked write of R6/R7. In every other case it is 0 in the cycle after an access or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset into the space |
| acc_size | input | 2 | 0 = byte, 1 = 16-bit, 2/3 = 32-bit |
| wr_data | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| remap_pulse | output | 1 | Decode windows must be recomputed |

## Verification
Three instances run in parallel, with header types 0x00, 0x80 and 0x01. Every pattern therefore separates the two protection maps and confirms that both type-0 encodings behave the same. Byte writes at all 256 offsets, read back as 16-bit words, check the protection lists and the little-endian order. All-ones dword writes to every aligned offset expose the region masks, the forced type bits, the kept ROM enable and the zero-size regions that fall back to the byte path. A second dword pattern with varying upper bits, a ROM write with the enable clear, and accesses at unaligned offsets finish the sweep, and remap_pulse is compared after every access.

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
  parameter logic [15:0]    VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]    DEVICE_ID   = 16'h0A51,
  parameter logic [7:0]     REVISION    = 8'h02,
  parameter logic [23:0]    CLASS_CODE  = 24'h010180,
  parameter logic [7:0]     HEADER_TYPE = 8'h00,
  parameter logic [7:0]     INT_PIN     = 8'h01,
  parameter logic [6*32-1:0] BAR_SIZE   = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_0010},
  parameter logic [6*32-1:0] BAR_TYPE   = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0001},
  parameter logic [31:0]    ROM_SIZE    = 32'h0000_0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [7:0]  acc_offset,
  input  logic [1:0]  acc_size,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        remap_pulse
);
  localparam int          NBAR     = 6;
  localparam int          NBYTES   = 256;
  localparam logic [7:0]  BAR_LO   = 8'h10;
  localparam logic [7:0]  BAR_END  = BAR_LO + 8'(4 * NBAR);
  localparam logic [7:0]  ROM_OFS  = 8'h30;
  localparam logic [7:0]  CMD_OFS  = 8'h04;
  localparam logic [7:0]  HDR_OFS  = 8'h0E;

  function automatic logic [7:0] reset_byte(int a);
    logic [7:0] v;
    int n, k;
    v = 8'h00;
    if (a == 0)       v = VENDOR_ID[7:0];
    else if (a == 1)  v = VENDOR_ID[15:8];
    else if (a == 2)  v = DEVICE_ID[7:0];
    else if (a == 3)  v = DEVICE_ID[15:8];
    else if (a == 8)  v = REVISION;
    else if (a >= 9 && a <= 11) v = CLASS_CODE[(a-9)*8 +: 8];
    else if (a == int'(HDR_OFS)) v = HEADER_TYPE;
    else if (a == 8'h3D) v = INT_PIN;
    else if (a >= int'(BAR_LO) && a < int'(BAR_END)) begin
      n = (a - int'(BAR_LO)) / 4;
      k = (a - int'(BAR_LO)) % 4;
      if (BAR_SIZE[n*32 +: 32] != 32'h0) v = BAR_TYPE[n*32 + k*8 +: 8];
    end
    return v;
  endfunction

  function automatic logic is_locked(logic [7:0] hdr, int a);
    logic common;
    common = (a <= 3) || (a >= 8 && a <= 11) || (a == 14) || (a == 8'h3D);
    if (hdr == 8'h00 || hdr == 8'h80)
      return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    return common || (a >= 8'h38 && a <= 8'h3B);
  endfunction

  logic [7:0]  cfg_q [NBYTES];
  logic [7:0]  base;
  logic [3:0]  nbytes;
  logic        wr_go, in_bar, in_rom, mask_path, cmd_hit;
  logic [7:0]  bar_off;
  logic [31:0] reg_size, reg_type, low_bits, wword;
  logic        we    [NBYTES];
  logic [7:0]  wbyte [NBYTES];
  logic [31:0] rd_next;

  always_comb begin
    unique case (acc_size)
      2'd0:    begin nbytes = 4'd1; base = acc_offset; end
      2'd1:    begin nbytes = 4'd2; base = {acc_offset[7:1], 1'b0}; end
      default: begin nbytes = 4'd4; base = {acc_offset[7:2], 2'b00}; end
    endcase
  end

  assign wr_go   = acc_valid & acc_write;
  assign bar_off = base - BAR_LO;
  assign in_bar  = (nbytes == 4'd4) && (base >= BAR_LO) && (base < BAR_END);
  assign in_rom  = (nbytes == 4'd4) && (base == ROM_OFS);

  always_comb begin
    reg_size = ROM_SIZE;
    reg_type = 32'h0;
    if (in_bar) begin
      reg_size = 32'h0;
      for (int n = 0; n < NBAR; n++)
        if (bar_off[7:2] == 6'(n)) begin
          reg_size = BAR_SIZE[n*32 +: 32];
          reg_type = BAR_TYPE[n*32 +: 32];
        end
    end
  end

  assign mask_path = (in_bar | in_rom) && (reg_size != 32'h0);
  assign low_bits  = reg_size - 32'h1;
  assign wword     = !mask_path ? wr_data :
                     in_bar     ? ((wr_data & ~low_bits) | reg_type) :
                                  (wr_data & (~low_bits | 32'h1));
  assign cmd_hit   = (base < CMD_OFS + 8'd2) && ({1'b0, base} + {5'b0, nbytes} > {1'b0, CMD_OFS});

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      logic [7:0] lane;
      lane     = 8'(i) - base;
      wbyte[i] = wword[lane[1:0]*8 +: 8];
      we[i]    = wr_go && (lane < {4'b0, nbytes}) &&
                 (mask_path || !is_locked(cfg_q[HDR_OFS], i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cfg_q[i] <= reset_byte(i);
    end else begin
      for (int i = 0; i < NBYTES; i++)
        if (we[i]) cfg_q[i] <= wbyte[i];
    end
  end

  always_comb begin
    rd_next = 32'h0;
    for (int k = 0; k < 4; k++)
      if (4'(k) < nbytes) rd_next[k*8 +: 8] = cfg_q[base + 8'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= 32'h0;
      remap_pulse <= 1'b0;
    end else begin
      if (acc_valid && !acc_write) rd_data <= rd_next;
      remap_pulse <= wr_go && (mask_path || cmd_hit);
    end
  end
endmodule

// File: rtl/cfg_space_regfile_chk.sv
module cfg_space_regfile_chk #(
  parameter logic [15:0] VENDOR_ID   = 16'h0,
  parameter logic [7:0]  HEADER_TYPE = 8'h0,
  parameter logic [31:0] BAR0_SIZE   = 32'h0,
  parameter logic [31:0] BAR0_TYPE   = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [7:0]  acc_offset,
  input logic [1:0]  acc_size,
  input logic [31:0] rd_data,
  input logic        remap_pulse
);
  localparam bit TYPE0 = (HEADER_TYPE == 8'h00) || (HEADER_TYPE == 8'h80);
  localparam bit BAR0_ON = (BAR0_SIZE != 32'h0);
  localparam logic [31:0] BAR0_LOW = BAR0_SIZE - 32'h1;

  logic wr, rd;
  assign wr = acc_valid && acc_write;
  assign rd = acc_valid && !acc_write;

  AST_REMAP_CMD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_size == 2'd1 && acc_offset[7:1] == 7'h02) |=> remap_pulse); // R9
  AST_REMAP_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_size == 2'd0 && acc_offset == 8'h04) |=> remap_pulse); // R9
  AST_REMAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !remap_pulse); // R10
  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && acc_size == 2'd0) |=> rd_data[31:8] == 24'h0); // R2
  AST_VENDOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && acc_size == 2'd1 && acc_offset[7:1] == 7'h00) |=> rd_data == {16'h0, VENDOR_ID}); // R1
  AST_BAR0_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (TYPE0 && BAR0_ON && rd && acc_size[1] && acc_offset[7:2] == 6'h04) |=>
      ((rd_data & BAR0_LOW) == (BAR0_TYPE & BAR0_LOW))); // R6
endmodule

bind cfg_space_regfile cfg_space_regfile_chk #(
  .VENDOR_ID(VENDOR_ID), .HEADER_TYPE(HEADER_TYPE),
  .BAR0_SIZE(BAR_SIZE[31:0]), .BAR0_TYPE(BAR_TYPE[31:0])
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_offset(acc_offset), .acc_size(acc_size), .rd_data(rd_data),
  .remap_pulse(remap_pulse)
);

// File: tb/test_cfg_space_regfile.sv
module test_cfg_space_regfile;
  localparam logic [15:0] VID = 16'hC0DE;
  localparam logic [15:0] DID = 16'h0A51;
  localparam logic [7:0]  REV = 8'h02;
  localparam logic [23:0] CLS = 24'h010180;
  localparam logic [7:0]  PIN = 8'h01;
  localparam logic [6*32-1:0] BSZ = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_0010};
  localparam logic [6*32-1:0] BTY = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0001};
  localparam logic [31:0] RSZ = 32'h0000_0800;
  localparam logic [7:0]  HDR [3] = '{8'h00, 8'h80, 8'h01};

  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [7:0]  acc_offset = 0;
  logic [1:0]  acc_size = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rdv [3];
  logic        rmp [3];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl [3][256];
  logic       exp_rm [3];

  always #5 clk = ~clk;

  cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .HEADER_TYPE(8'h00), .INT_PIN(PIN), .BAR_SIZE(BSZ), .BAR_TYPE(BTY), .ROM_SIZE(RSZ))
  i_cfg_space_regfile (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_size(acc_size), .wr_data(wr_data), .rd_data(rdv[0]), .remap_pulse(rmp[0]));

  cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .HEADER_TYPE(8'h80), .INT_PIN(PIN), .BAR_SIZE(BSZ), .BAR_TYPE(BTY), .ROM_SIZE(RSZ))
  i_cfg_space_regfile_h80 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_size(acc_size), .wr_data(wr_data), .rd_data(rdv[1]), .remap_pulse(rmp[1]));

  cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .HEADER_TYPE(8'h01), .INT_PIN(PIN), .BAR_SIZE(BSZ), .BAR_TYPE(BTY), .ROM_SIZE(RSZ))
  i_cfg_space_regfile_h01 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_size(acc_size), .wr_data(wr_data), .rd_data(rdv[2]), .remap_pulse(rmp[2]));

  function automatic logic [7:0] init_val(int h, int a);
    if (a < 2) return VID[a*8 +: 8];
    if (a < 4) return DID[(a-2)*8 +: 8];
    if (a == 8) return REV;
    if (a >= 9 && a <= 11) return CLS[(a-9)*8 +: 8];
    if (a == 14) return HDR[h];
    if (a == 61) return PIN;
    if (a >= 16 && a < 40 && BSZ[((a-16)/4)*32 +: 32] != 0) return BTY[(a-16)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic bit locked(int h, int a);
    bit c;
    c = (a < 4) || (a >= 8 && a < 12) || a == 14 || a == 61;
    if (HDR[h] == 8'h00 || HDR[h] == 8'h80) return c || (a >= 16 && a < 40) || (a >= 48 && a < 52);
    return c || (a >= 56 && a < 60);
  endfunction

  function automatic int span(logic [1:0] sz);
    return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
  endfunction

  function automatic int align(int off, logic [1:0] sz);
    return off - (off % span(sz));
  endfunction

  task automatic model_write(int off, logic [1:0] sz, logic [31:0] d);
    int b, n;
    logic [31:0] s, v;
    bit masked;
    b = align(off, sz); n = span(sz);
    masked = 0; s = 0; v = d;
    if (n == 4 && b >= 16 && b < 40) begin
      s = BSZ[((b-16)/4)*32 +: 32];
      if (s != 0) begin masked = 1; v = (d & ~(s - 1)) | BTY[((b-16)/4)*32 +: 32]; end
    end else if (n == 4 && b == 48 && RSZ != 0) begin
      masked = 1; v = d & (~(RSZ - 1) | 32'h1);
    end
    for (int h = 0; h < 3; h++) begin
      for (int k = 0; k < n; k++)
        if (masked || !locked(h, b + k)) mdl[h][b + k] = v[k*8 +: 8];
      exp_rm[h] = masked || (b < 6 && b + n > 4);
    end
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv, int h, int off);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s inst=%0d off=%02h actual=%08h expected=%08h", req, h, off, act, expv);
    end
  endtask

  task automatic wr(int off, logic [1:0] sz, logic [31:0] d, string req);
    acc_valid = 1; acc_write = 1; acc_offset = 8'(off); acc_size = sz; wr_data = d;
    model_write(off, sz, d);
    @(negedge clk);
    acc_valid = 0;
    for (int h = 0; h < 3; h++)
      check(rmp[h] == exp_rm[h], req, 32'(rmp[h]), 32'(exp_rm[h]), h, off);
  endtask

  task automatic rd(int off, logic [1:0] sz, string req);
    int b, n;
    logic [31:0] e;
    b = align(off, sz); n = span(sz);
    acc_valid = 1; acc_write = 0; acc_offset = 8'(off); acc_size = sz; wr_data = 32'hA5A5_A5A5;
    @(negedge clk);
    acc_valid = 0;
    for (int h = 0; h < 3; h++) begin
      e = 0;
      for (int k = 0; k < n; k++) e[k*8 +: 8] = mdl[h][b + k];
      check(rdv[h] == e, req, rdv[h], e, h, off);
      check(rmp[h] == 1'b0, "R10", 32'(rmp[h]), 32'h0, h, off);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int h = 0; h < 3; h++) begin
      for (int a = 0; a < 256; a++) mdl[h][a] = init_val(h, a);
      exp_rm[h] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset image, byte reads
    for (int a = 0; a < 256; a++) rd(a, 2'd0, "R1");
    // R3 R4 R5: byte writes with junk above the byte lane; R9 on 0x04/0x05
    for (int a = 0; a < 256; a++) wr(a, 2'd0, {24'hDEADBE, 8'(a * 37 + 5)}, "R9");
    for (int a = 0; a < 256; a += 2) rd(a, 2'd1, "R4_R5");
    // R2 R3: word writes, dword reads
    for (int a = 0; a < 256; a += 2) wr(a, 2'd1, {16'hFFFF, 16'(a * 16'h0101 ^ 16'h5AC3)}, "R9");
    for (int a = 0; a < 256; a += 4) rd(a, 2'd2, "R3");
    // R6 R7 R8 R10: all-ones dword writes everywhere
    for (int a = 0; a < 256; a += 4) wr(a, 2'd2, 32'hFFFF_FFFF, "R10");
    for (int a = 0; a < 256; a += 4) rd(a, 2'd3, "R6_R7_R8");
    // second dword pattern, byte reads
    for (int a = 0; a < 256; a += 4) wr(a, 2'd2, 32'h1357_9BDF ^ {a[7:0], 24'h0}, "R10");
    for (int a = 0; a < 256; a++) rd(a, 2'd0, "R6_R8");
    // R7: ROM enable clear and set
    wr(8'h30, 2'd2, 32'hABCD_E7FE, "R7");
    rd(8'h30, 2'd2, "R7");
    wr(8'h30, 2'd2, 32'h0000_0001, "R7");
    rd(8'h30, 2'd2, "R7");
    // R2: unaligned offsets are aligned down
    wr(8'h41, 2'd1, 32'h0000_BEEF, "R2");
    rd(8'h43, 2'd2, "R2");
    rd(8'h41, 2'd1, "R2");
    wr(8'h05, 2'd1, 32'h0000_0306, "R9");
    rd(8'h13, 2'd2, "R6");
    // R10: write beside the command register must not pulse
    wr(8'h06, 2'd1, 32'h0000_0000, "R10");
    wr(8'h03, 2'd0, 32'h0000_0000, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule